// File: doc/BRIEF.md
# Two-Pass Frequency Counter with Boundary Check

This block measures how many rising edges of an input signal arrive during a gate of a set number of reference ticks. It does not need to gate or single-step the input to recover the part of a prescaled count that is left over. It runs two gates back to back instead. The first gate counts through a 256:1 prescaler and gives the coarse count. The second gate counts every edge, and its low eight bits stand in for the remainder that the first gate lost. During the first gate the coarse count is captured three times: a few ticks before the gate closes, at the close, and a few ticks after it. If these captures disagree, a prescaler rollover happened close to the boundary. If the remainder is very small, it could belong to either side of a rollover. In both cases the block raises an error flag and reports only the coarse part, which is then low by anywhere from 0 to 255.

An autorange mode takes a single gate instead. It begins at divisor 1 and doubles the divisor after every gate in which the count overflows, up to 256. It reports the count of the first gate that fits, shifted back to full scale. The remainder lost to the prescaler is accepted in this mode. The mode is selected when the start strobe is accepted. The result and the flag stay on the outputs until the next measurement finishes.

Top module: `twopass_freq_counter`

## Requirements
- R1: After synchronous reset, `valid_o`, `err_o` and `count_o` are all 0.
- R2: Rising edges are counted in the clock cycles strictly after the cycle that opens a pass and strictly before the cycle of the pass's closing tick. The coarse count is floor(edges/256) modulo 2^CNT_W, captured at the GATE_TICKS-th tick after the start strobe. It occupies `count_o[CNT_W+7:8]`.
- R3: The second pass opens in the cycle of tick GATE_TICKS+CAP_OFS of the first pass and closes at its own GATE_TICKS-th tick. Its remainder is its edge count modulo 256.
- R4: In two-pass mode with no error, `count_o` = coarse×256 + remainder and `err_o` = 0. A remainder equal to LOW_THR is not an error.
- R5: In two-pass mode, a remainder below LOW_THR sets `err_o` = 1 and forces `count_o[7:0]` to 0.
- R6: In two-pass mode, if the coarse captures at ticks GATE_TICKS−CAP_OFS, GATE_TICKS and GATE_TICKS+CAP_OFS are not all equal, `err_o` = 1 and `count_o` = coarse×256.
- R7: `valid_o` is a one-cycle pulse, exactly one per measurement. It rises one cycle after the closing tick of the last pass.
- R8: A start strobe is ignored while a measurement is in progress.
- R9: In autorange mode (`autorange_i` = 1 at start), each try is one gate of GATE_TICKS ticks at divisor 2^s, for s = 0, 1, … 8. A try overflows when floor(edges/2^s) ≥ 2^CNT_W. Each retry opens in the cycle of the failing tick. The first try that fits gives `count_o` = floor(edges/2^s)×2^s and `err_o` = 0.
- R10: In autorange mode, if the try at divisor 256 also overflows, `count_o` is all ones and `err_o` = 1.
- R11: `count_o` and `err_o` hold their values in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_i | input | 1 | Signal under measurement, synchronous to clk |
| ref_tick_i | input | 1 | One-cycle timebase tick |
| start_i | input | 1 | Start strobe, accepted only when idle |
| autorange_i | input | 1 | Selects the autorange mode when start is accepted |
| count_o | output | CNT_W+8 | Measured edge count |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Estimate unreliable, or autorange overflow |

## Verification
Two events can land on the same cycle. A reference tick that captures the coarse count, or closes or reopens a pass, can coincide with a rising edge of the signal. That edge must be left out of the capture, and it is lost when the pass reopens. This is provoked with continuous square waves whose periods are not matched to the tick spacing. It is also provoked with a fast signal that makes the prescaler roll over between the early and late captures. The bench's cycle model of the requirements judges each result, so both the exact count and the flag decision are checked.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;

    localparam int unsigned FC_PRE_BITS = 8;
    localparam int unsigned FC_SHIFT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COARSE,
        ST_FINE,
        ST_AUTO,
        ST_EVAL
    } fc_state_e;

    typedef struct packed {
        logic low_rem;
        logic drift_early;
        logic drift_late;
    } fc_flags_t;

    // Prescaler bits that must all be set before the main counter steps.
    function automatic logic [FC_PRE_BITS-1:0] fc_mask(input logic [FC_SHIFT_W-1:0] sh);
        return ~({FC_PRE_BITS{1'b1}} << sh);
    endfunction

endpackage

// File: rtl/fcnt_edge.sv
module fcnt_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/fcnt_scaler.sv
module fcnt_scaler
    import fcnt_pkg::*;
#(
    parameter int unsigned CW    = 16,
    parameter int unsigned LIM_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  rise_i,
    input  logic [FC_SHIFT_W-1:0] shift_i,
    output logic [CW-1:0]         cnt_o,
    output logic                  ovf_o
);
    logic [FC_PRE_BITS-1:0] pre_q;
    logic [FC_PRE_BITS-1:0] mask;
    logic                   step;

    assign mask = fc_mask(shift_i);
    assign step = rise_i && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (rise_i) begin
            pre_q <= pre_q + 1'b1;
            if (step) begin
                cnt_o <= cnt_o + 1'b1;
                if (&cnt_o[LIM_W-1:0]) ovf_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcnt_gate.sv
module fcnt_gate #(
    parameter int unsigned GATE_TICKS = 100,
    parameter int unsigned CAP_OFS    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic       tick_i,
    output logic [2:0] hit_o
);
    localparam int unsigned TW = $clog2(GATE_TICKS + CAP_OFS + 1);
    localparam int unsigned MARK [3] = '{GATE_TICKS - CAP_OFS, GATE_TICKS, GATE_TICKS + CAP_OFS};

    logic [TW-1:0] tcnt_q;
    logic [TW-1:0] nxt;

    assign nxt = tcnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr_i)          tcnt_q <= '0;
        else if (run_i && tick_i)  tcnt_q <= nxt;
    end

    for (genvar g = 0; g < 3; g++) begin : g_mark
        assign hit_o[g] = run_i && tick_i && (nxt == TW'(MARK[g]));
    end
endmodule

// File: rtl/twopass_freq_counter.sv
module twopass_freq_counter
    import fcnt_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned GATE_TICKS = 100,
    parameter int unsigned CAP_OFS    = 1,
    parameter int unsigned LOW_THR    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sig_i,
    input  logic               ref_tick_i,
    input  logic               start_i,
    input  logic               autorange_i,
    output logic [CNT_W+7:0]   count_o,
    output logic               valid_o,
    output logic               err_o
);
    localparam int unsigned CW = (CNT_W > FC_PRE_BITS) ? CNT_W : FC_PRE_BITS;
    localparam int unsigned OW = CNT_W + FC_PRE_BITS;

    fc_state_e              state_q;
    logic [FC_SHIFT_W-1:0]  shift_q;
    logic                   auto_q;
    logic                   ovf_q;
    logic [FC_PRE_BITS-1:0] rem_q;
    logic [CNT_W-1:0]       cap_q [3];

    logic                   rise;
    logic [CW-1:0]          main_cnt;
    logic                   main_ovf;
    logic [2:0]             hit;
    logic                   run;
    logic                   retry;
    logic                   clr;
    fc_flags_t              flags;
    logic                   two_err;
    logic [OW-1:0]          two_val;
    logic [OW-1:0]          auto_val;

    assign run   = (state_q == ST_COARSE) || (state_q == ST_FINE) || (state_q == ST_AUTO);
    assign retry = (state_q == ST_AUTO) && hit[1] && main_ovf && (shift_q < FC_SHIFT_W'(FC_PRE_BITS));
    assign clr   = ((state_q == ST_IDLE) && start_i) || ((state_q == ST_COARSE) && hit[2]) || retry;

    fcnt_edge i_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (sig_i),
        .rise_o (rise)
    );

    fcnt_scaler #(.CW(CW), .LIM_W(CNT_W)) i_scaler (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr),
        .rise_i  (rise),
        .shift_i (shift_q),
        .cnt_o   (main_cnt),
        .ovf_o   (main_ovf)
    );

    fcnt_gate #(.GATE_TICKS(GATE_TICKS), .CAP_OFS(CAP_OFS)) i_gate (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .clr_i  (clr),
        .tick_i (ref_tick_i),
        .hit_o  (hit)
    );

    // Coarse snapshots: early, at close, late. Slot 1 also keeps the autorange count.
    for (genvar g = 0; g < 3; g++) begin : g_cap
        logic take;
        assign take = ((state_q == ST_COARSE) && hit[g]) ||
                      ((g == 1) && (state_q == ST_AUTO) && hit[g]);
        always_ff @(posedge clk) begin
            if (rst)       cap_q[g] <= '0;
            else if (take) cap_q[g] <= main_cnt[CNT_W-1:0];
        end
    end

    always_comb begin
        flags.low_rem     = rem_q < FC_PRE_BITS'(LOW_THR);
        flags.drift_early = cap_q[0] != cap_q[1];
        flags.drift_late  = cap_q[1] != cap_q[2];
        two_err           = |flags;
        two_val           = {cap_q[1], (two_err ? '0 : rem_q)};
        auto_val          = OW'(cap_q[1]) << shift_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            auto_q  <= 1'b0;
            ovf_q   <= 1'b0;
            rem_q   <= '0;
            count_o <= '0;
            err_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        auto_q  <= autorange_i;
                        state_q <= autorange_i ? ST_AUTO : ST_COARSE;
                        shift_q <= autorange_i ? '0 : FC_SHIFT_W'(FC_PRE_BITS);
                    end
                end
                ST_COARSE: begin
                    if (hit[2]) begin
                        state_q <= ST_FINE;
                        shift_q <= '0;
                    end
                end
                ST_FINE: begin
                    if (hit[1]) begin
                        rem_q   <= main_cnt[FC_PRE_BITS-1:0];
                        state_q <= ST_EVAL;
                    end
                end
                ST_AUTO: begin
                    if (hit[1]) begin
                        if (retry) begin
                            shift_q <= shift_q + 1'b1;
                        end else begin
                            ovf_q   <= main_ovf;
                            state_q <= ST_EVAL;
                        end
                    end
                end
                ST_EVAL: begin
                    valid_o <= 1'b1;
                    state_q <= ST_IDLE;
                    if (auto_q) begin
                        count_o <= ovf_q ? '1 : auto_val;
                        err_o   <= ovf_q;
                    end else begin
                        count_o <= two_val;
                        err_o   <= two_err;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twopass_freq_counter_chk.sv
module twopass_freq_counter_chk
    import fcnt_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned LOW_THR = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  valid_o,
    input logic                  err_o,
    input logic [CNT_W+7:0]      count_o,
    input logic                  auto_q,
    input logic [FC_SHIFT_W-1:0] shift_q,
    input fc_state_e             state_q
);
    localparam int unsigned OW = CNT_W + FC_PRE_BITS;

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r7_after_eval: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(state_q) == ST_EVAL);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(count_o) && $stable(err_o)));

    a_r5_err_low_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_o && err_o && !auto_q) |-> (count_o[FC_PRE_BITS-1:0] == '0));

    a_r4_rem_above_thr: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o && !auto_q) |-> (count_o[FC_PRE_BITS-1:0] >= FC_PRE_BITS'(LOW_THR)));

    a_r10_auto_all_ones: assert property (@(posedge clk) disable iff (rst)
        (valid_o && err_o && auto_q) |-> (&count_o));

    a_r9_auto_aligned: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o && auto_q) |-> ((count_o & ((OW'(1) << shift_q) - OW'(1))) == '0));
endmodule

bind twopass_freq_counter twopass_freq_counter_chk #(.CNT_W(CNT_W), .LOW_THR(LOW_THR)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_o (valid_o),
    .err_o   (err_o),
    .count_o (count_o),
    .auto_q  (auto_q),
    .shift_q (shift_q),
    .state_q (state_q)
);

// File: tb/test_twopass_freq_counter.sv
module test_twopass_freq_counter;
    localparam int C   = 3;
    localparam int G   = 4;
    localparam int O   = 1;
    localparam int THR = 4;
    localparam int OW  = C + 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sig = 1'b0;
    logic          tick = 1'b0;
    logic          start = 1'b0;
    logic          au = 1'b0;
    logic [OW-1:0] cnt;
    logic          vld;
    logic          er;

    twopass_freq_counter #(.CNT_W(C), .GATE_TICKS(G), .CAP_OFS(O), .LOW_THR(THR)) i_twopass_freq_counter (
        .clk         (clk),
        .rst         (rst),
        .sig_i       (sig),
        .ref_tick_i  (tick),
        .start_i     (start),
        .autorange_i (au),
        .count_o     (cnt),
        .valid_o     (vld),
        .err_o       (er)
    );

    always #5 clk = ~clk;

    int    errs = 0;
    int    checks = 0;
    bit    fin = 0;
    string req = "R1";

    // Requirement model state
    int ph = 0, tkc = 0, e = 0, s = 0, cb = 0, cm = 0, ca = 0, rem = 0, v = 0;
    bit mauto = 0, movf = 0, prev = 0, exp_valid = 0, mdone = 0, exp_err = 0;
    int exp_cnt = 0;
    int vcount = 0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic int coarse(input int n, input int sh);
        return (n >> sh) % (1 << C);
    endfunction

    task automatic model(input bit sg, input bit tk, input bit st, input bit a);
        bit rz;
        rz = sg && !prev;
        prev = sg;
        exp_valid = 0;
        case (ph)
            0: if (st) begin
                mauto = a; ph = a ? 3 : 1; s = a ? 0 : 8; tkc = 0; e = 0;
            end
            1: begin
                if (tk) begin
                    tkc++;
                    if (tkc == G - O) cb = coarse(e, 8);
                    if (tkc == G)     cm = coarse(e, 8);
                    if (tkc == G + O) begin
                        ca = coarse(e, 8); ph = 2; tkc = 0; e = 0; rz = 0;
                    end
                end
                if (rz) e++;
            end
            2: begin
                if (tk) begin
                    tkc++;
                    if (tkc == G) begin rem = e % 256; ph = 4; end
                end
                if (rz) e++;
            end
            3: begin
                if (tk) begin
                    tkc++;
                    if (tkc == G) begin
                        v = e >> s;
                        movf = v >= (1 << C);
                        if (movf && s < 8) begin
                            s++; tkc = 0; e = 0; rz = 0;
                        end else begin
                            cm = v % (1 << C); ph = 4;
                        end
                    end
                end
                if (rz) e++;
            end
            default: begin
                exp_valid = 1; mdone = 1; ph = 0;
                if (mauto) begin
                    exp_err = movf;
                    exp_cnt = movf ? (1 << OW) - 1 : (cm << s);
                end else begin
                    exp_err = (rem < THR) || (cb != cm) || (cm != ca);
                    exp_cnt = cm * 256 + (exp_err ? 0 : rem);
                end
            end
        endcase
    endtask

    task automatic step(input bit sg, input bit tk, input bit st, input bit a);
        @(negedge clk);
        if (vld || exp_valid) begin
            chk(vld == exp_valid, {req, " R7 valid"}, vld, exp_valid);
            if (vld) vcount++;
            if (exp_valid) begin
                chk(int'(cnt) == exp_cnt, {req, " count"}, cnt, exp_cnt);
                chk(er == exp_err, {req, " err"}, er, exp_err);
            end
        end
        sig = sg; tick = tk; start = st; au = a;
        model(sg, tk, st, a);
    endtask

    // mode 0: square wave of half period h; mode 1: burst of k1/k2 edges early in each pass
    task automatic meas(input string r, input bit a, input int mode, input int h, input int t,
                        input int k1, input int k2, input bit busy);
        int lc = 0;
        int tgt;
        bit sg;
        req = r;
        mdone = 0;
        vcount = 0;
        while (!mdone && lc < 150000) begin
            if (mode == 1) begin
                tgt = (ph == 1 || ph == 3) ? k1 : ((ph == 2) ? k2 : 0);
                sg = (ph != 0 && ph != 4 && e < tgt) ? !sig : 1'b0;
            end else begin
                sg = (lc > 0) && (((lc / h) % 2) == 1);
            end
            step(sg, (lc % t) == t - 1, (lc == 0) || (busy && lc == 2 * t + 3), a);
            lc++;
        end
        step(0, 0, 0, 0);
        repeat (3) step(0, 0, 0, 0);
        chk(vcount == 1, {r, " R7 one pulse"}, vcount, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(vld == 0, "R1 valid", vld, 0);
        chk(er == 0, "R1 err", er, 0);
        chk(cnt == 0, "R1 count", cnt, 0);

        // R4 and R3: remainder exactly at threshold is accepted
        meas("R4 R3 burst", 0, 1, 1, 500, 768, 256 + THR, 0);
        // R5: remainder just below threshold
        meas("R5 low rem", 0, 1, 1, 500, 768, THR - 1, 0);
        // R5: silent signal
        meas("R5 silent", 0, 1, 1, 200, 0, 0, 0);
        // R6: fast signal rolls the prescaler between early and late captures
        meas("R6 drift", 0, 0, 1, 600, 0, 0, 0);
        chk(er == 1, "R6 flag raised", er, 1);
        // R2: coarse count wraps modulo 2^CNT_W
        meas("R2 wrap", 0, 1, 1, 1200, 2304, 10, 0);
        // R8: start strobe during a measurement is ignored
        meas("R8 busy start", 0, 0, 3, 300, 0, 0, 1);
        // R9: autorange picks divisor 1 and divisor 16
        meas("R9 auto small", 1, 1, 1, 200, 5, 0, 0);
        meas("R9 auto mid", 1, 1, 1, 200, 100, 0, 0);
        // R10: every divisor overflows
        meas("R10 auto full", 1, 0, 1, 1100, 0, 0, 0);

        // R11: outputs hold while idle with signal and ticks moving
        req = "R11";
        for (int i = 0; i < 40; i++) step(i[0], (i % 7) == 6, 0, 0);
        @(negedge clk);
        chk(int'(cnt) == exp_cnt, "R11 count held", cnt, exp_cnt);
        chk(er == exp_err, "R11 err held", er, exp_err);

        // Random square waves in both modes
        for (int n = 0; n < 10; n++) begin
            bit ra;
            int rh, rt;
            ra = 1'($urandom % 2);
            rh = 1 + ($urandom % 6);
            rt = 100 + ($urandom % 200);
            meas(ra ? "R9 random" : "R4 R6 random", ra, 0, rh, rt, 0, 0, 0);
        end

        fin = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            errs++;
            checks++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule